// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 39-bit virtual address into a 56-bit physical address. It does this by walking a three-level radix page table held in physical memory. A requester presents a 64-bit virtual address, an access type and a privilege flag. The walker reads one table entry per level through a single-outstanding memory read port. It then reports either the physical address together with the leaf's flag bits, or a page fault.

The physical page of the root table comes from an input that mirrors the address-translation control register. Each table is one 4096-byte page of 512 eight-byte entries. The 27-bit virtual page number is cut into three 9-bit indices, used from the most significant field (root) down to the least significant field (final level). No entries are cached. Every request costs one memory read per level visited.

Top module: `pgwalk_top`

## Requirements
- R1: After reset, `req_ready` is 1, and `done` and `mem_req_valid` are 0.
- R2: The entry read at each level is at address `table_ppn*4096 + index*8`. The root uses `root_ppn` with virtual bits 38:30. The middle table uses the root entry's page number with bits 29:21. The final table uses the middle entry's page number with bits 20:12.
- R3: Entry layout is V=bit 0, R=bit 1, W=bit 2, X=bit 3, U=bit 4, and page number = bits 53:10. A permitted final-level leaf gives `paddr = {leaf page number, vaddr[11:0]}`, `fault=0`, and `leaf_flags` = entry bits 4:0.
- R4: An entry with V=0 at any level ends the walk with `fault=1`, `paddr=0` and `leaf_flags=0`. No further reads are issued.
- R5: Access type encodes read=0, write=1, execute=2. The final leaf must have R, W or X set, respectively, or the request faults.
- R6: When `req_user`=1, a leaf with U=0 faults. Supervisor requests (`req_user`=0) may use leaves with either U value.
- R7: A valid entry with W=1 and R=0 is malformed and faults for every access type.
- R8: A leaf (R or X set) found at the root or middle level faults. So does a pointer entry (R=0, X=0) found at the final level.
- R9: Bits 63:39 of `req_vaddr` must all equal bit 38. Otherwise the request faults without any memory read.
- R10: At most one memory read is outstanding. `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready`. While a walk is in progress, `req_ready` is 0 and `req_valid` is ignored.
- R11: `done` is a one-cycle pulse, and `fault`, `paddr` and `leaf_flags` are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_ppn | input | 44 | Physical page number of the root table |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_vaddr | input | 64 | Virtual address to translate |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| req_user | input | 1 | 1 for user-mode access, 0 for supervisor |
| done | output | 1 | One-cycle result pulse |
| fault | output | 1 | Page fault, valid with done |
| paddr | output | 56 | Translated physical address, valid with done |
| leaf_flags | output | 5 | Leaf entry bits 4:0, valid with done |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 56 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry contents |

## Verification
The assertions take for granted that the memory side returns exactly one response for each accepted read, never sends a response unasked, and may stall `mem_req_ready` for any number of cycles. The bench's memory model answers each handshake with exactly one response on the following cycle and is otherwise silent. Its optional stall mode toggles `mem_req_ready` every cycle. Requests are only raised when `req_ready` is high, except in the one scenario that deliberately drives `req_valid` during a walk to show it is ignored.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int XLEN    = 64;
  localparam int VA_W    = 39;
  localparam int PA_W    = 56;
  localparam int PPN_W   = 44;
  localparam int OFF_W   = 12;
  localparam int IDX_W   = 9;
  localparam int LVLS    = 3;
  localparam int ENT_SH  = 3;
  localparam int PPN_LSB = 10;
  localparam int FLG_W   = 5;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } acc_e;

  typedef struct packed {
    logic u;
    logic x;
    logic w;
    logic r;
    logic v;
  } pte_flags_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } walk_st_e;
endpackage

// File: rtl/pgwalk_addr_gen.sv
module pgwalk_addr_gen
  import pgwalk_pkg::*;
#(
  parameter int P_PA_W   = PA_W,
  parameter int P_PPN_W  = PPN_W,
  parameter int P_OFF_W  = OFF_W,
  parameter int P_IDX_W  = IDX_W,
  parameter int P_LVLS   = LVLS,
  parameter int P_ENT_SH = ENT_SH
) (
  input  logic [P_LVLS*P_IDX_W-1:0]               vpn,
  input  logic [((P_LVLS>1)?$clog2(P_LVLS):1)-1:0] lvl,
  input  logic [P_PPN_W-1:0]                      base_ppn,
  output logic [P_PA_W-1:0]                       ent_addr
);
  localparam int LVL_W = (P_LVLS > 1) ? $clog2(P_LVLS) : 1;
  localparam int PAD_W = P_PA_W - P_IDX_W - P_ENT_SH;

  logic [P_IDX_W-1:0] idx_arr [P_LVLS];
  logic [P_IDX_W-1:0] idx_sel;

  // one index field per level, lowest field belongs to the final table
  for (genvar g = 0; g < P_LVLS; g++) begin : g_idx
    assign idx_arr[g] = vpn[g*P_IDX_W +: P_IDX_W];
  end

  always_comb begin
    idx_sel = '0;
    for (int i = 0; i < P_LVLS; i++) begin
      if (lvl == LVL_W'(i)) idx_sel = idx_arr[i];
    end
  end

  // table base is page aligned, the scaled index fits inside the page offset
  assign ent_addr = {base_ppn, {P_OFF_W{1'b0}}}
                  | {{PAD_W{1'b0}}, idx_sel, {P_ENT_SH{1'b0}}};
endmodule

// File: rtl/pgwalk_pte_eval.sv
module pgwalk_pte_eval
  import pgwalk_pkg::*;
#(
  parameter int P_XLEN    = XLEN,
  parameter int P_PPN_W   = PPN_W,
  parameter int P_PPN_LSB = PPN_LSB,
  parameter int P_FLG_W   = FLG_W
) (
  input  logic [P_XLEN-1:0]  pte,
  input  logic [1:0]         acc,
  input  logic               user,
  input  logic               last,
  output logic               ev_fault,
  output logic               ev_leaf,
  output logic [P_PPN_W-1:0] ev_ppn,
  output logic [P_FLG_W-1:0] ev_flags
);
  pte_flags_t fl;
  logic       malformed;
  logic       perm_ok;
  logic       user_ok;
  logic       unused_bits;

  assign fl          = pte_flags_t'(pte[P_FLG_W-1:0]);
  assign ev_ppn      = pte[P_PPN_LSB +: P_PPN_W];
  assign ev_flags    = pte[P_FLG_W-1:0];
  assign unused_bits = ^{pte[P_XLEN-1:P_PPN_LSB+P_PPN_W], pte[P_PPN_LSB-1:P_FLG_W]};

  assign malformed = !fl.v || (fl.w && !fl.r);
  assign ev_leaf   = fl.r || fl.x;
  assign user_ok   = !user || fl.u;

  always_comb begin
    unique case (acc)
      ACC_READ:  perm_ok = fl.r;
      ACC_WRITE: perm_ok = fl.w;
      ACC_EXEC:  perm_ok = fl.x;
      default:   perm_ok = 1'b0;
    endcase
  end

  // leaves only at the final level, pointers only above it
  always_comb begin
    if (malformed)      ev_fault = 1'b1;
    else if (ev_leaf)   ev_fault = !last || !perm_ok || !user_ok;
    else                ev_fault = last;
  end
endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
#(
  parameter int P_XLEN  = XLEN,
  parameter int P_VA_W  = VA_W,
  parameter int P_PA_W  = PA_W,
  parameter int P_PPN_W = PPN_W,
  parameter int P_OFF_W = OFF_W,
  parameter int P_IDX_W = IDX_W,
  parameter int P_LVLS  = LVLS,
  parameter int P_FLG_W = FLG_W
) (
  input  logic                                    clk,
  input  logic                                    rst_n,
  input  logic [P_PPN_W-1:0]                      root_ppn,
  input  logic                                    req_valid,
  input  logic [P_XLEN-1:0]                       req_vaddr,
  input  logic [1:0]                              req_acc,
  input  logic                                    req_user,
  input  logic                                    mem_req_ready,
  input  logic                                    mem_rsp_valid,
  input  logic                                    ev_fault,
  input  logic                                    ev_leaf,
  input  logic [P_PPN_W-1:0]                      ev_ppn,
  input  logic [P_FLG_W-1:0]                      ev_flags,
  output logic [((P_LVLS>1)?$clog2(P_LVLS):1)-1:0] lvl,
  output logic [P_PPN_W-1:0]                      base_ppn,
  output logic [P_LVLS*P_IDX_W-1:0]               vpn,
  output logic [1:0]                              acc,
  output logic                                    user,
  output logic                                    last,
  output logic                                    req_ready,
  output logic                                    mem_req_valid,
  output logic                                    done,
  output logic                                    fault,
  output logic [P_PA_W-1:0]                       paddr,
  output logic [P_FLG_W-1:0]                      leaf_flags
);
  localparam int LVL_W = (P_LVLS > 1) ? $clog2(P_LVLS) : 1;
  localparam int VPN_W = P_LVLS * P_IDX_W;

  walk_st_e            st_q, st_d;
  logic [LVL_W-1:0]    lvl_q, lvl_d;
  logic [P_PPN_W-1:0]  base_q, base_d;
  logic [VPN_W-1:0]    vpn_q;
  logic [P_OFF_W-1:0]  off_q;
  logic [1:0]          acc_q;
  logic                user_q;
  logic                flt_q, flt_d;
  logic [P_PA_W-1:0]   pa_q, pa_d;
  logic [P_FLG_W-1:0]  flg_q, flg_d;
  logic                cap_en, walk_en, res_en;
  logic                canon;

  // sign-extension bits above the usable range must copy the top usable bit
  assign canon = (&req_vaddr[P_XLEN-1:P_VA_W-1]) || !(|req_vaddr[P_XLEN-1:P_VA_W-1]);

  always_comb begin
    st_d    = st_q;
    lvl_d   = lvl_q;
    base_d  = base_q;
    cap_en  = 1'b0;
    walk_en = 1'b0;
    res_en  = 1'b0;
    flt_d   = 1'b0;
    pa_d    = '0;
    flg_d   = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_en  = 1'b1;
          walk_en = 1'b1;
          lvl_d   = LVL_W'(P_LVLS - 1);
          base_d  = root_ppn;
          if (canon) begin
            st_d = ST_ISSUE;
          end else begin
            st_d   = ST_FIN;
            res_en = 1'b1;
            flt_d  = 1'b1;
          end
        end
      end
      ST_ISSUE: begin
        if (mem_req_ready) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if (ev_fault) begin
            st_d   = ST_FIN;
            res_en = 1'b1;
            flt_d  = 1'b1;
          end else if (ev_leaf) begin
            st_d   = ST_FIN;
            res_en = 1'b1;
            pa_d   = P_PA_W'({ev_ppn, off_q});
            flg_d  = ev_flags;
          end else begin
            st_d    = ST_ISSUE;
            walk_en = 1'b1;
            lvl_d   = lvl_q - 1'b1;
            base_d  = ev_ppn;
          end
        end
      end
      ST_FIN: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      lvl_q  <= '0;
      base_q <= '0;
      vpn_q  <= '0;
      off_q  <= '0;
      acc_q  <= '0;
      user_q <= 1'b0;
      flt_q  <= 1'b0;
      pa_q   <= '0;
      flg_q  <= '0;
    end else begin
      st_q <= st_d;
      if (walk_en) begin
        lvl_q  <= lvl_d;
        base_q <= base_d;
      end
      if (cap_en) begin
        vpn_q  <= req_vaddr[P_VA_W-1:P_OFF_W];
        off_q  <= req_vaddr[P_OFF_W-1:0];
        acc_q  <= req_acc;
        user_q <= req_user;
      end
      if (res_en) begin
        flt_q <= flt_d;
        pa_q  <= pa_d;
        flg_q <= flg_d;
      end
    end
  end

  assign lvl           = lvl_q;
  assign base_ppn      = base_q;
  assign vpn           = vpn_q;
  assign acc           = acc_q;
  assign user          = user_q;
  assign last          = (lvl_q == '0);
  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_ISSUE);
  assign done          = (st_q == ST_FIN);
  assign fault         = flt_q;
  assign paddr         = pa_q;
  assign leaf_flags    = flg_q;
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int P_XLEN = XLEN,
  parameter int P_VA_W = VA_W,
  parameter int P_PA_W = PA_W,
  parameter int P_PPN_W = PPN_W,
  parameter int P_OFF_W = OFF_W,
  parameter int P_IDX_W = IDX_W,
  parameter int P_LVLS = LVLS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [P_PPN_W-1:0] root_ppn,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [P_XLEN-1:0]  req_vaddr,
  input  logic [1:0]         req_acc,
  input  logic               req_user,
  output logic               done,
  output logic               fault,
  output logic [P_PA_W-1:0]  paddr,
  output logic [FLG_W-1:0]   leaf_flags,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [P_PA_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [P_XLEN-1:0]  mem_rsp_data
);
  localparam int LVL_W = (P_LVLS > 1) ? $clog2(P_LVLS) : 1;
  localparam int VPN_W = P_LVLS * P_IDX_W;

  logic [LVL_W-1:0]   lvl;
  logic [P_PPN_W-1:0] base_ppn;
  logic [VPN_W-1:0]   vpn;
  logic [1:0]         acc;
  logic               user;
  logic               last;
  logic               ev_fault;
  logic               ev_leaf;
  logic [P_PPN_W-1:0] ev_ppn;
  logic [FLG_W-1:0]   ev_flags;

  pgwalk_ctrl #(
    .P_XLEN(P_XLEN), .P_VA_W(P_VA_W), .P_PA_W(P_PA_W), .P_PPN_W(P_PPN_W),
    .P_OFF_W(P_OFF_W), .P_IDX_W(P_IDX_W), .P_LVLS(P_LVLS), .P_FLG_W(FLG_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .root_ppn(root_ppn),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_acc(req_acc), .req_user(req_user),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .ev_fault(ev_fault), .ev_leaf(ev_leaf), .ev_ppn(ev_ppn), .ev_flags(ev_flags),
    .lvl(lvl), .base_ppn(base_ppn), .vpn(vpn), .acc(acc), .user(user), .last(last),
    .req_ready(req_ready), .mem_req_valid(mem_req_valid), .done(done),
    .fault(fault), .paddr(paddr), .leaf_flags(leaf_flags)
  );

  pgwalk_addr_gen #(
    .P_PA_W(P_PA_W), .P_PPN_W(P_PPN_W), .P_OFF_W(P_OFF_W),
    .P_IDX_W(P_IDX_W), .P_LVLS(P_LVLS), .P_ENT_SH(ENT_SH)
  ) u_addr (
    .vpn(vpn), .lvl(lvl), .base_ppn(base_ppn), .ent_addr(mem_req_addr)
  );

  pgwalk_pte_eval #(
    .P_XLEN(P_XLEN), .P_PPN_W(P_PPN_W), .P_PPN_LSB(PPN_LSB), .P_FLG_W(FLG_W)
  ) u_eval (
    .pte(mem_rsp_data), .acc(acc), .user(user), .last(last),
    .ev_fault(ev_fault), .ev_leaf(ev_leaf), .ev_ppn(ev_ppn), .ev_flags(ev_flags)
  );
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk
  import pgwalk_pkg::*;
#(
  parameter int P_XLEN = XLEN,
  parameter int P_PA_W = PA_W,
  parameter int P_OFF_W = OFF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [P_XLEN-1:0] req_vaddr,
  input logic              done,
  input logic              fault,
  input logic [P_PA_W-1:0] paddr,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [P_PA_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid
);
  logic               outst_q;
  logic [P_OFF_W-1:0] off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= 1'b0;
      off_q   <= '0;
    end else begin
      if (mem_req_valid && mem_req_ready) outst_q <= 1'b1;
      else if (mem_rsp_valid)             outst_q <= 1'b0;
      if (req_valid && req_ready) off_q <= req_vaddr[P_OFF_W-1:0];
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10
  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !outst_q); // R10
  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (paddr == '0)); // R4
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (paddr[P_OFF_W-1:0] == off_q)); // R3
  AST_ENTRY_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[ENT_SH-1:0] == '0)); // R2
endmodule

bind pgwalk_top pgwalk_chk #(
  .P_XLEN(P_XLEN), .P_PA_W(P_PA_W), .P_OFF_W(P_OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .done(done), .fault(fault), .paddr(paddr),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/pgwalk_top_tb.sv
module pgwalk_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [43:0] ROOT = 44'h100;
  localparam logic [43:0] MID  = 44'h200;
  localparam logic [43:0] FINT = 44'h300;
  localparam logic [43:0] LEAFA = 44'hABCDE12345;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_vaddr;
  logic [1:0]  req_acc;
  logic        req_user;
  logic        done;
  logic        fault;
  logic [55:0] paddr;
  logic [4:0]  leaf_flags;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [55:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;

  logic        stall_mode;
  logic        rdy_tgl;
  int          rd_cnt;
  logic [55:0] rd_log [8];
  logic [63:0] pmem [logic [55:0]];
  int          checks;
  int          errors;

  pgwalk_top u_dut (
    .clk(clk), .rst_n(rst_n), .root_ppn(ROOT),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_acc(req_acc), .req_user(req_user),
    .done(done), .fault(fault), .paddr(paddr), .leaf_flags(leaf_flags),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_req_ready = rdy_tgl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_tgl <= 1'b1;
    else        rdy_tgl <= stall_mode ? ~rdy_tgl : 1'b1;
  end

  // memory model: one response the cycle after each accepted read
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      rd_cnt        <= 0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid     <= 1'b1;
        mem_rsp_data      <= pmem.exists(mem_req_addr) ? pmem[mem_req_addr] : 64'd0;
        rd_log[rd_cnt % 8] <= mem_req_addr;
        rd_cnt            <= rd_cnt + 1;
      end
    end
  end

  function automatic logic [63:0] mk_pte(input logic [43:0] ppn, input logic [4:0] flg);
    return {10'd0, ppn, 5'd0, flg};
  endfunction

  function automatic logic [63:0] mk_va(input logic [8:0] v2, input logic [8:0] v1,
                                        input logic [8:0] v0, input logic [11:0] off);
    logic [38:0] a;
    a = {v2, v1, v0, off};
    return {{25{a[38]}}, a};
  endfunction

  function automatic logic [55:0] ent(input logic [43:0] base, input int idx);
    return {base, 12'd0} + 56'(idx * 8);
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic do_walk(input string tag, input logic [63:0] va, input logic [1:0] acc,
                         input logic usr, input logic exp_f, input logic [55:0] exp_pa,
                         input logic [4:0] exp_flg, input int exp_rd, output int rd_start);
    int waited;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    rd_start  = rd_cnt;
    req_valid = 1'b1;
    req_vaddr = va;
    req_acc   = acc;
    req_user  = usr;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!done && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    chk({tag, " R11 done seen"}, 64'(done), 64'd1);
    chk({tag, " fault"}, 64'(fault), 64'(exp_f));
    chk({tag, " paddr"}, 64'(paddr), 64'(exp_pa));
    chk({tag, " flags"}, 64'(leaf_flags), 64'(exp_flg));
    chk({tag, " read count"}, 64'(rd_cnt - rd_start), 64'(exp_rd));
    @(negedge clk);
    chk({tag, " R11 done one cycle"}, 64'(done), 64'd0);
  endtask

  task automatic t_reset();
    chk("R1 req_ready after reset", 64'(req_ready), 64'd1);
    chk("R1 done after reset", 64'(done), 64'd0);
    chk("R1 mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
  endtask

  task automatic t_basic();
    int s;
    do_walk("R3 user read", mk_va(9'd5, 9'd7, 9'd9, 12'hABC), 2'd0, 1'b1,
            1'b0, {LEAFA, 12'hABC}, 5'h17, 3, s);
    chk("R2 root entry addr",   64'(rd_log[s % 8]),       64'(ent(ROOT, 5)));
    chk("R2 middle entry addr", 64'(rd_log[(s+1) % 8]),   64'(ent(MID, 7)));
    chk("R2 final entry addr",  64'(rd_log[(s+2) % 8]),   64'(ent(FINT, 9)));
  endtask

  task automatic t_perm();
    int s;
    do_walk("R5 write RW page", mk_va(9'd5, 9'd7, 9'd9, 12'h010), 2'd1, 1'b1,
            1'b0, {LEAFA, 12'h010}, 5'h17, 3, s);
    do_walk("R5 exec no X", mk_va(9'd5, 9'd7, 9'd9, 12'h010), 2'd2, 1'b1,
            1'b0 ^ 1'b1, 56'd0, 5'd0, 3, s);
    do_walk("R5 write read-only", mk_va(9'd5, 9'd7, 9'd14, 12'h020), 2'd1, 1'b1,
            1'b1, 56'd0, 5'd0, 3, s);
    do_walk("R5 read read-only", mk_va(9'd5, 9'd7, 9'd14, 12'h020), 2'd0, 1'b1,
            1'b0, {44'h99, 12'h020}, 5'h13, 3, s);
    do_walk("R5 super read exec-only", mk_va(9'd5, 9'd7, 9'd10, 12'h030), 2'd0, 1'b0,
            1'b1, 56'd0, 5'd0, 3, s);
  endtask

  task automatic t_user();
    int s;
    do_walk("R6 user exec on U=0", mk_va(9'd5, 9'd7, 9'd10, 12'h040), 2'd2, 1'b1,
            1'b1, 56'd0, 5'd0, 3, s);
    do_walk("R6 super exec on U=0", mk_va(9'd5, 9'd7, 9'd10, 12'h040), 2'd2, 1'b0,
            1'b0, {44'h55, 12'h040}, 5'h09, 3, s);
    do_walk("R6 super read on U=1", mk_va(9'd5, 9'd7, 9'd9, 12'h050), 2'd0, 1'b0,
            1'b0, {LEAFA, 12'h050}, 5'h17, 3, s);
  endtask

  task automatic t_malformed();
    int s;
    do_walk("R7 write W-only", mk_va(9'd5, 9'd7, 9'd11, 12'h060), 2'd1, 1'b1,
            1'b1, 56'd0, 5'd0, 3, s);
    do_walk("R7 read W-only", mk_va(9'd5, 9'd7, 9'd11, 12'h060), 2'd0, 1'b1,
            1'b1, 56'd0, 5'd0, 3, s);
  endtask

  task automatic t_invalid();
    int s;
    do_walk("R4 invalid final", mk_va(9'd5, 9'd7, 9'd12, 12'h070), 2'd0, 1'b0,
            1'b1, 56'd0, 5'd0, 3, s);
    do_walk("R4 invalid middle", mk_va(9'd5, 9'd8, 9'd9, 12'h070), 2'd0, 1'b0,
            1'b1, 56'd0, 5'd0, 2, s);
  endtask

  task automatic t_level();
    int s;
    do_walk("R8 leaf at root", mk_va(9'd6, 9'd0, 9'd0, 12'h080), 2'd0, 1'b0,
            1'b1, 56'd0, 5'd0, 1, s);
    do_walk("R8 pointer at final", mk_va(9'd5, 9'd7, 9'd13, 12'h080), 2'd0, 1'b0,
            1'b1, 56'd0, 5'd0, 3, s);
  endtask

  task automatic t_canon();
    int s;
    do_walk("R9 non-canonical", mk_va(9'd5, 9'd7, 9'd9, 12'hABC) ^ (64'd1 << 45), 2'd0, 1'b0,
            1'b1, 56'd0, 5'd0, 0, s);
    do_walk("R9 upper half", mk_va(9'h105, 9'd7, 9'd9, 12'h0F0), 2'd0, 1'b1,
            1'b0, {LEAFA, 12'h0F0}, 5'h17, 3, s);
  endtask

  task automatic t_stall();
    int s;
    stall_mode = 1'b1;
    do_walk("R10 stalled memory", mk_va(9'd5, 9'd7, 9'd9, 12'h123), 2'd0, 1'b1,
            1'b0, {LEAFA, 12'h123}, 5'h17, 3, s);
    chk("R10 stalled root addr",  64'(rd_log[s % 8]),     64'(ent(ROOT, 5)));
    chk("R10 stalled final addr", 64'(rd_log[(s+2) % 8]), 64'(ent(FINT, 9)));
    stall_mode = 1'b0;
  endtask

  task automatic t_busy();
    int s;
    int waited;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    s = rd_cnt;
    req_valid = 1'b1;
    req_vaddr = mk_va(9'd5, 9'd7, 9'd9, 12'h456);
    req_acc   = 2'd0;
    req_user  = 1'b1;
    @(negedge clk);
    chk("R10 not ready while busy", 64'(req_ready), 64'd0);
    req_vaddr = mk_va(9'd6, 9'd0, 9'd0, 12'h000) ^ (64'd1 << 50);
    req_acc   = 2'd2;
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!done && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    chk("R10 busy done", 64'(done), 64'd1);
    chk("R10 busy result fault", 64'(fault), 64'd0);
    chk("R10 busy result paddr", 64'(paddr), 64'({LEAFA, 12'h456}));
    chk("R10 busy reads", 64'(rd_cnt - s), 64'd3);
    repeat (4) @(negedge clk);
    chk("R10 no second result", 64'(done), 64'd0);
    chk("R10 no extra reads", 64'(rd_cnt - s), 64'd3);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL R11 watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks     = 0;
    errors     = 0;
    stall_mode = 1'b0;
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_vaddr  = '0;
    req_acc    = '0;
    req_user   = 1'b0;

    pmem[ent(ROOT, 5)]     = mk_pte(MID, 5'h01);
    pmem[ent(ROOT, 6)]     = mk_pte(44'h777, 5'h03);
    pmem[ent(ROOT, 'h105)] = mk_pte(MID, 5'h01);
    pmem[ent(MID, 7)]      = mk_pte(FINT, 5'h01);
    pmem[ent(FINT, 9)]     = mk_pte(LEAFA, 5'h17);
    pmem[ent(FINT, 10)]    = mk_pte(44'h55, 5'h09);
    pmem[ent(FINT, 11)]    = mk_pte(44'h66, 5'h15);
    pmem[ent(FINT, 13)]    = mk_pte(44'h88, 5'h01);
    pmem[ent(FINT, 14)]    = mk_pte(44'h99, 5'h13);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    t_reset();
    t_basic();
    t_perm();
    t_user();
    t_malformed();
    t_invalid();
    t_level();
    t_canon();
    t_stall();
    t_busy();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule